// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Bank

This block holds the digital state behind four converter channels. Each channel keeps a staging register and an active register, both DATA_W bits wide, and a power state. The active register drives the channel's output code. A command word arrives with a one-cycle `cmd_valid` strobe. The top two bits of the word select the load behaviour. The next two bits pick a channel. The low DATA_W bits are the payload. This layout lets software stage new values on several channels and then move them to the outputs together, or write one channel straight through.

One reserved code of the load and select fields carries power-down commands. A power-down command places one channel, or all four, in one of three states: a 1 kΩ load to ground, a 100 kΩ load to ground, or a floating output. The block only reports the chosen state. The actual switching is done elsewhere. The command input has no ready signal: the block takes one word on every cycle in which `cmd_valid` is high, and it never applies back-pressure.

Top module: `quad_dac_regbank`

## Requirements
- R1: Load code 00 (cmd_word[15:14]) writes the payload cmd_word[11:0] into the staging register of the channel named by cmd_word[13:12] (00 = ch0, 01 = ch1, 10 = ch2, 11 = ch3). No output changes.
- R2: Load code 01 copies the selected channel's staging value into its active register. The payload is ignored.
- R3: Load code 10 writes the payload into both the staging register and the active register of the selected channel.
- R4: Load code 11 acts on all four channels. With select 00 it writes the payload to every staging register. With select 01 it copies every staging register to its active register. With select 10 it writes the payload to every staging register and every active register.
- R5: Load code 11 with select 11 is a power-down command. If bit 11 is 1, the command applies to all channels and bits 10:9 are ignored. If bit 11 is 0, bits 10:9 name the single channel. Only the power state of the target channels changes; codes and staging values stay as they were.
- R6: Bits 8:7 of a power-down command choose the state: 00 float, 01 1 kΩ, 10 100 kΩ, 11 float. Bits 6:0 are ignored. `pwr_state` for channel c sits at bits [2c+1:2c] and is encoded 00 powered, 01 1 kΩ, 10 100 kΩ, 11 float. `hiz_o[c]` is 1 exactly when that channel floats.
- R7: While reset is held and after it is released, every code is zero, every staging value is zero and every channel is powered.
- R8: Any command that writes a channel's active register (R2, R3, R4) also returns that channel to the powered state.
- R9: Every update appears on the first rising clock edge after the strobe. When `cmd_valid` is low, no output changes, whatever value `cmd_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one word per high cycle |
| cmd_word | input | DATA_W+4 | Command: load code, select, payload |
| code_out | output | 4*DATA_W | Active codes, channel c at [c*DATA_W +: DATA_W] |
| pwr_state | output | 8 | Power state per channel, 2 bits each |
| hiz_o | output | 4 | Floating-output flag per channel |

## Verification
The assertions check four behaviours on every cycle. An idle strobe leaves all outputs unchanged. A staging-only write never moves a code. A both-registers write lands its payload on the chosen channel and powers that channel up. A global float command floats every channel and keeps the codes. Other behaviours can only be seen through a sequence of commands, so the bench's scenarios cover them: that staged values survive until a transfer, that a transfer ignores its payload, the broadcast forms, and the power-down field decoding. To do this, the bench sweeps every power-down field value and every load and select combination against an arithmetic model, then runs a long pseudo-random command stream.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  typedef enum logic [1:0] {
    LD_STAGE = 2'b00,
    LD_XFER  = 2'b01,
    LD_BOTH  = 2'b10,
    LD_WIDE  = 2'b11
  } load_e;

  typedef enum logic [1:0] {
    PS_ON    = 2'b00,
    PS_1K    = 2'b01,
    PS_100K  = 2'b10,
    PS_FLOAT = 2'b11
  } pwr_e;

  // Map the command's two-bit mode field onto the reported power state.
  function automatic pwr_e pd_map(input logic [1:0] fld);
    case (fld)
      2'b01:   return PS_1K;
      2'b10:   return PS_100K;
      default: return PS_FLOAT;
    endcase
  endfunction

endpackage

// File: rtl/qdr_cmd_decode.sv
module qdr_cmd_decode
  import qdr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 2,
  localparam int NCH   = 1 << SEL_W,
  localparam int CMD_W = DATA_W + 2 + SEL_W
) (
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [NCH-1:0]    stg_we,
  output logic [NCH-1:0]    act_ld,
  output logic [NCH-1:0]    act_cp,
  output logic [NCH-1:0]    pd_we,
  output pwr_e              pd_val,
  output logic [DATA_W-1:0] data
);

  load_e            load;
  logic [SEL_W-1:0] sel;
  logic [SEL_W-1:0] pd_ch;
  logic             pd_all;
  logic [NCH-1:0]   sel_oh;
  logic [NCH-1:0]   pd_oh;

  assign load   = load_e'(cmd_word[CMD_W-1 -: 2]);
  assign sel    = cmd_word[DATA_W +: SEL_W];
  assign data   = cmd_word[DATA_W-1:0];
  assign pd_all = cmd_word[DATA_W-1];
  assign pd_ch  = cmd_word[DATA_W-2 -: SEL_W];
  assign pd_val = pd_map(cmd_word[DATA_W-2-SEL_W -: 2]);

  always_comb begin
    sel_oh        = '0;
    sel_oh[sel]   = 1'b1;
    pd_oh         = '0;
    pd_oh[pd_ch]  = 1'b1;
    stg_we        = '0;
    act_ld        = '0;
    act_cp        = '0;
    pd_we         = '0;
    if (cmd_valid) begin
      case (load)
        LD_STAGE: stg_we = sel_oh;
        LD_XFER:  act_cp = sel_oh;
        LD_BOTH: begin
          stg_we = sel_oh;
          act_ld = sel_oh;
        end
        default: begin
          if (sel == SEL_W'(0)) begin
            stg_we = '1;
          end else if (sel == SEL_W'(1)) begin
            act_cp = '1;
          end else if (sel == SEL_W'(2)) begin
            stg_we = '1;
            act_ld = '1;
          end else begin
            pd_we = pd_all ? '1 : pd_oh;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/qdr_chan.sv
module qdr_chan
  import qdr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_we,
  input  logic              act_ld,
  input  logic              act_cp,
  input  logic              pd_we,
  input  pwr_e              pd_val,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] act_q,
  output pwr_e              ps_q
);

  logic [DATA_W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q <= '0;
      act_q <= '0;
      ps_q  <= PS_ON;
    end else begin
      if (stg_we) stg_q <= data;
      if (act_ld)      act_q <= data;
      else if (act_cp) act_q <= stg_q;
      if (act_ld || act_cp) ps_q <= PS_ON;
      else if (pd_we)       ps_q <= pd_val;
    end
  end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdr_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int SEL_W = 2,
  localparam int NCH   = 1 << SEL_W,
  localparam int CMD_W = DATA_W + 2 + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [CMD_W-1:0]      cmd_word,
  output logic [NCH*DATA_W-1:0] code_out,
  output logic [NCH*2-1:0]      pwr_state,
  output logic [NCH-1:0]        hiz_o
);

  logic [NCH-1:0]    stg_we;
  logic [NCH-1:0]    act_ld;
  logic [NCH-1:0]    act_cp;
  logic [NCH-1:0]    pd_we;
  pwr_e              pd_val;
  logic [DATA_W-1:0] data;

  qdr_cmd_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .stg_we    (stg_we),
    .act_ld    (act_ld),
    .act_cp    (act_cp),
    .pd_we     (pd_we),
    .pd_val    (pd_val),
    .data      (data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwr_e ps;
    qdr_chan #(.DATA_W(DATA_W)) i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .stg_we (stg_we[c]),
      .act_ld (act_ld[c]),
      .act_cp (act_cp[c]),
      .pd_we  (pd_we[c]),
      .pd_val (pd_val),
      .data   (data),
      .act_q  (code_out[c*DATA_W +: DATA_W]),
      .ps_q   (ps)
    );
    assign pwr_state[c*2 +: 2] = ps;
    assign hiz_o[c]            = (ps == PS_FLOAT);
  end

endmodule

// File: rtl/qdr_checker.sv
module qdr_checker #(
  parameter int DATA_W = 12,
  localparam int NCH   = 4,
  localparam int CMD_W = DATA_W + 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [CMD_W-1:0]      cmd_word,
  input logic [NCH*DATA_W-1:0] code_out,
  input logic [NCH*2-1:0]      pwr_state,
  input logic [NCH-1:0]        hiz_o
);

  AST_IDLE_HOLDS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(code_out) && $stable(pwr_state) && $stable(hiz_o)); // R9

  AST_STAGE_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[CMD_W-1 -: 2] == 2'b00 |=> $stable(code_out) && $stable(pwr_state)); // R1

  AST_PD_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[CMD_W-1 -: 4] == 4'hF && cmd_word[DATA_W-1]
      && cmd_word[DATA_W-4 -: 2] == 2'b00
    |=> hiz_o == '1 && $stable(code_out)); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_BOTH_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[CMD_W-1 -: 2] == 2'b10 && cmd_word[DATA_W +: 2] == 2'(c)
      |=> code_out[c*DATA_W +: DATA_W] == $past(cmd_word[DATA_W-1:0])); // R3

    AST_WRITE_POWERS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[CMD_W-1 -: 2] == 2'b10 && cmd_word[DATA_W +: 2] == 2'(c)
      |=> pwr_state[c*2 +: 2] == 2'b00 && !hiz_o[c]); // R8
  end

endmodule

bind quad_dac_regbank qdr_checker #(.DATA_W(DATA_W)) i_qdr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .code_out  (code_out),
  .pwr_state (pwr_state),
  .hiz_o     (hiz_o)
);

// File: tb/test_quad_dac_regbank.sv
module test_quad_dac_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 12;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [DW+3:0]     cmd_word = '0;
  logic [NCH*DW-1:0] code_out;
  logic [NCH*2-1:0]  pwr_state;
  logic [NCH-1:0]    hiz_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_stg [NCH];
  logic [DW-1:0] m_act [NCH];
  logic [1:0]    m_ps  [NCH];
  logic [15:0]   lfsr = 16'hACE1;

  quad_dac_regbank #(.DATA_W(DW)) i_quad_dac_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .code_out  (code_out),
    .pwr_state (pwr_state),
    .hiz_o     (hiz_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(tag, $sformatf("code ch%0d", c), int'(code_out[c*DW +: DW]), int'(m_act[c]));
      chk(tag, $sformatf("pwr ch%0d", c), int'(pwr_state[c*2 +: 2]), int'(m_ps[c]));
      chk(tag, $sformatf("hiz ch%0d", c), int'(hiz_o[c]), (m_ps[c] == 2'b11) ? 1 : 0);
    end
  endtask

  // Arithmetic model of the command set, built from the requirements.
  task automatic model(input logic [15:0] w);
    logic [1:0]    ld;
    logic [1:0]    sl;
    logic [DW-1:0] d;
    logic [1:0]    pm;
    ld = w[15:14];
    sl = w[13:12];
    d  = w[11:0];
    pm = (w[8:7] == 2'b01) ? 2'b01 : (w[8:7] == 2'b10) ? 2'b10 : 2'b11;
    for (int c = 0; c < NCH; c++) begin
      bit hit;
      hit = (ld != 2'b11) ? (sl == 2'(c)) : 1'b1;
      if (hit) begin
        if (ld == 2'b00 || (ld == 2'b11 && sl == 2'b00)) m_stg[c] = d;
        else if (ld == 2'b01 || (ld == 2'b11 && sl == 2'b01)) begin
          m_act[c] = m_stg[c];
          m_ps[c]  = 2'b00;
        end else if (ld == 2'b10 || (ld == 2'b11 && sl == 2'b10)) begin
          m_stg[c] = d;
          m_act[c] = d;
          m_ps[c]  = 2'b00;
        end else if (w[11] || w[10:9] == 2'(c)) begin
          m_ps[c] = pm;
        end
      end
    end
  endtask

  task automatic send(input logic [15:0] w, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = ~w;
    model(w);
    compare_all(tag);
  endtask

  task automatic idle(input logic [15:0] w, input string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = w;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_stg[c] = '0;
      m_act[c] = '0;
      m_ps[c]  = 2'b00;
    end
    repeat (3) @(negedge clk);
    compare_all("R7");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R7");

    // Per-channel staging, transfer (junk payload) and direct writes.
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [DW-1:0] p;
        p = DW'(c * 12'h3A5 + k * 12'h111) ^ DW'(k << 9);
        send({2'b00, 2'(c), p}, "R1");
        send({2'b01, 2'(c), ~p}, "R2");
        send({2'b10, 2'(c), p ^ 12'hFFF}, "R3");
        send({2'b00, 2'(c), p ^ 12'h5A5}, "R1");
      end
    end

    // Broadcast forms.
    send({4'b1100, 12'hABC}, "R4");
    send({4'b1101, 12'h0F0}, "R4");
    send({4'b1000, 12'h321}, "R4");
    send({4'b1110, 12'h123}, "R4");
    send({4'b1100, 12'hFFF}, "R4");
    send({4'b1101, 12'h000}, "R4");

    // Every value of the power-down field bits 11:7, with varying don't-care bits.
    for (int v = 0; v < 32; v++) begin
      send({4'b1111, 5'(v), 7'(v * 37)}, "R5");
      if (v % 4 == 3) send({2'b10, 2'(v / 4), 12'(v * 97)}, "R8");
    end
    for (int c = 0; c < NCH; c++)
      for (int m = 0; m < 4; m++)
        send({4'b1111, 1'b0, 2'(c), 2'(m), 7'h7F}, "R6");

    // Return from power-down by transfer and by broadcast.
    send({4'b1111, 1'b1, 2'b00, 2'b00, 7'h00}, "R5");
    send({2'b01, 2'b10, 12'hEEE}, "R8");
    send({4'b1111, 1'b1, 2'b11, 2'b01, 7'h00}, "R6");
    send({4'b1101, 12'h555}, "R8");

    // Idle cycles with command-like junk on the bus.
    for (int i = 0; i < 24; i++) begin
      step_lfsr();
      idle(lfsr, "R9");
    end

    // Pseudo-random command stream mixed with idles.
    for (int i = 0; i < 600; i++) begin
      step_lfsr();
      if (lfsr[0] && lfsr[5]) idle(lfsr, "R9");
      else send(lfsr, "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule